// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked request port and an asynchronous static RAM of 128K bytes. The RAM has one select that is active low and one that is active high, plus an output enable and a write enable. The block turns each accepted request into one complete read or write cycle on the RAM pins. Each phase of a cycle is held for a whole number of clock cycles. These counts are found at elaboration by dividing the RAM's nanosecond limits by the clock period and rounding up.

A client raises `req_valid` with an address, a direction flag and, for a write, a data byte. The request is taken on a clock edge where `req_ready` is high. The block latches the request, so the client may change its inputs at once. Completion is signalled by a single-cycle `rsp_done`, and a read returns its byte on `rsp_rdata`. The controller drives the bidirectional data bus only around its own write pulse. When idle, it parks the RAM in standby.

With the default 10 ns clock, the phase counts are as follows. A read holds output enable low for 7 cycles (RD). A write holds write enable low for 6 cycles (WP). The write recovery phase lasts 1 cycle (HOLD). The read turnaround lasts 3 cycles (TURN).

Top module: `sram_async_ctl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the RAM pins are in standby: `ram_cs1_n`=1, `ram_cs2`=0, `ram_oe_n`=1, `ram_we_n`=1, and the controller does not drive `ram_dq`.
- R2: A request is accepted on a rising edge with `req_valid`=1 and `req_ready`=1. `req_ready` then stays low until the cycle ends. For both directions, `rsp_done` becomes visible 8 clock edges after the accepting edge.
- R3: In a read, `ram_cs1_n`=0 and `ram_cs2`=1 for one setup cycle, with `ram_oe_n`=1. Then `ram_oe_n` is low for RD = ceil(max(tAA, tOE)/Tclk) cycles. `ram_we_n` stays 1 throughout.
- R4: Read data is sampled from `ram_dq` on the edge that ends the output-enable window. It appears on `rsp_rdata` together with `rsp_done`, which is high for exactly one cycle.
- R5: In a write, one setup cycle with select active and `ram_we_n`=1 comes first. Then `ram_we_n` is low for WP = ceil(max(tWP, tCW, tDW)/Tclk) cycles, with select active and `ram_oe_n`=1.
- R6: The controller drives `ram_dq` with the write byte only while `ram_we_n` is low and during the recovery cycles after it rises. It never drives while `ram_oe_n` is low.
- R7: After `ram_we_n` rises, address and select stay active for HOLD = max(1, ceil(tWR/Tclk), ceil(tWC/Tclk)-1-WP) cycles.
- R8: After a read, the RAM is deselected for TURN = max(1, ceil(tOFF/Tclk)) cycles with `req_ready` low, before a new request can be accepted.
- R9: Address and write data on the RAM pins stay stable for the whole cycle. Changes on the request inputs after acceptance, including a `req_valid` held high while busy, have no effect.
- R10: A byte written to any 17-bit address, including 0 and 17'h1FFFF, is returned unchanged by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| ram_addr | output | 17 | RAM address pins |
| ram_dq | inout | 8 | RAM bidirectional data pins |
| ram_cs1_n | output | 1 | RAM select, active low |
| ram_cs2 | output | 1 | RAM select, active high |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
The hardest case to reach from the ports is a read sampled too early. A RAM model that answers at once would hide a short output-enable window. The bench's RAM model therefore drives a junk byte until output enable has been low for the full access count. A capture one cycle early then returns the wrong value. Bus turnaround is stressed by issuing a read directly after a write to another address. A request is also held valid during a busy write, to show it is neither taken nor able to disturb the latched address and data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_e;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic oe_n;
        logic we_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_STANDBY = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels belonging to each sequencer state.
    function automatic pin_ctl_t pins_for(input seq_state_e s);
        pin_ctl_t p;
        p = PINS_STANDBY;
        case (s)
            ST_SETUP: begin
                p.cs1_n = 1'b0;
                p.cs2   = 1'b1;
            end
            ST_RD_ACC: begin
                p.cs1_n = 1'b0;
                p.cs2   = 1'b1;
                p.oe_n  = 1'b0;
            end
            ST_WR_PULSE: begin
                p.cs1_n = 1'b0;
                p.cs2   = 1'b1;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
            end
            ST_WR_HOLD: begin
                p.cs1_n = 1'b0;
                p.cs2   = 1'b1;
                p.drive = 1'b1;
            end
            default: p = PINS_STANDBY;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int RD_CYC   = 7,
    parameter int WP_CYC   = 6,
    parameter int HOLD_CYC = 1,
    parameter int TURN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              capture,
    output logic              rsp_done,
    output pin_ctl_t          pins,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(HOLD_CYC, TURN_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e       state_q, state_n;
    logic             wr_q;
    logic             accept;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_exp;
    logic             wr_end;

    sram_cyc_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .load_val(t_val),
        .expired (t_exp)
    );

    always_comb begin
        state_n = state_q;
        accept  = 1'b0;
        t_load  = 1'b0;
        t_val   = '0;
        capture = 1'b0;
        wr_end  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_n = ST_SETUP;
                end
            end
            ST_SETUP: begin
                t_load = 1'b1;
                if (wr_q) begin
                    state_n = ST_WR_PULSE;
                    t_val   = CNT_W'(WP_CYC - 1);
                end else begin
                    state_n = ST_RD_ACC;
                    t_val   = CNT_W'(RD_CYC - 1);
                end
            end
            ST_RD_ACC: begin
                if (t_exp) begin
                    capture = 1'b1;
                    state_n = ST_RD_TURN;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (t_exp) state_n = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (t_exp) begin
                    state_n = ST_WR_HOLD;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_WR_HOLD: begin
                if (t_exp) begin
                    wr_end  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Pins are registered from the next state so the RAM strobes never glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pins     <= PINS_STANDBY;
            rsp_done <= 1'b0;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else begin
            state_q  <= state_n;
            pins     <= pins_for(state_n);
            rsp_done <= capture | wr_end;
            if (accept) begin
                wr_q    <= req_we;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drive,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    inout  wire  [DATA_W-1:0] ram_dq,
    output logic [DATA_W-1:0] rdata
);
    assign ram_dq = drive ? wdata : {DATA_W{1'bz}};

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= ram_dq;
        end
    end

    a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !drive);
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ACC_NS      = 70,
    parameter int T_OE_NS       = 25,
    parameter int T_WC_NS       = 70,
    parameter int T_WP_NS       = 35,
    parameter int T_CW_NS       = 60,
    parameter int T_DW_NS       = 35,
    parameter int T_WR_NS       = 5,
    parameter int T_OFF_NS      = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    inout  wire  [DATA_W-1:0] ram_dq,
    output logic              ram_cs1_n,
    output logic              ram_cs2,
    output logic              ram_oe_n,
    output logic              ram_we_n
);
    localparam int RD_CYC   = imax(1, ns_to_cyc(imax(T_ACC_NS, T_OE_NS), CLK_PERIOD_NS));
    localparam int WP_CYC   = imax(1, ns_to_cyc(imax(T_WP_NS, imax(T_CW_NS, T_DW_NS)), CLK_PERIOD_NS));
    localparam int HOLD_CYC = imax(1, imax(ns_to_cyc(T_WR_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - 1 - WP_CYC));
    localparam int TURN_CYC = imax(1, ns_to_cyc(T_OFF_NS, CLK_PERIOD_NS));

    pin_ctl_t          pins;
    logic              capture;
    logic [DATA_W-1:0] wdata_q;

    sram_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RD_CYC  (RD_CYC),
        .WP_CYC  (WP_CYC),
        .HOLD_CYC(HOLD_CYC),
        .TURN_CYC(TURN_CYC)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_we   (req_we),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_ready(req_ready),
        .capture  (capture),
        .rsp_done (rsp_done),
        .pins     (pins),
        .addr_q   (ram_addr),
        .wdata_q  (wdata_q)
    );

    sram_dq_port #(.DATA_W(DATA_W)) dq_i (
        .clk    (clk),
        .rst    (rst),
        .drive  (pins.drive),
        .oe_n   (pins.oe_n),
        .wdata  (wdata_q),
        .capture(capture),
        .ram_dq (ram_dq),
        .rdata  (rsp_rdata)
    );

    assign ram_cs1_n = pins.cs1_n;
    assign ram_cs2   = pins.cs2;
    assign ram_oe_n  = pins.oe_n;
    assign ram_we_n  = pins.we_n;

    a_r1_idle_standby: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ram_cs1_n && !ram_cs2 && ram_oe_n && ram_we_n && !pins.drive));
    a_r5_we_inside_select: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (!ram_cs1_n && ram_cs2 && ram_oe_n && pins.drive));
    a_r7_hold_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> (!ram_cs1_n && pins.drive));
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!ram_cs1_n && $past(!ram_cs1_n)) |-> $stable(ram_addr));
endmodule

// File: tb/sram_async_ctl_tb_top.sv
module sram_async_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    // Counts expected from the requirements at a 10 ns clock:
    // RD = ceil(70/10) = 7, WP = ceil(60/10) = 6, HOLD = 1, TURN = ceil(30/10) = 3.
    localparam int EXP_RD   = 7;
    localparam int EXP_WP   = 6;
    localparam int EXP_HOLD = 1;
    localparam int EXP_TURN = 3;
    localparam int EXP_LAT  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic [16:0] ram_addr;
    wire  [7:0]  ram_dq;
    logic        ram_cs1_n, ram_cs2, ram_oe_n, ram_we_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctl dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_dq(ram_dq),
        .ram_cs1_n(ram_cs1_n), .ram_cs2(ram_cs2), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
    );

    // RAM model: drives a junk byte until output enable has been low for the access count.
    logic [7:0] mem [logic [16:0]];
    int         oe_cnt = 0;
    logic       sel, mdl_drv;
    logic [7:0] mdl_val;
    assign sel     = !ram_cs1_n && ram_cs2;
    assign mdl_drv = sel && !ram_oe_n && ram_we_n;
    always_comb begin
        if (oe_cnt < EXP_RD) mdl_val = 8'hEE;
        else if (mem.exists(ram_addr)) mdl_val = mem[ram_addr];
        else mdl_val = 8'h00;
    end
    assign ram_dq = mdl_drv ? mdl_val : 8'hzz;

    always @(negedge clk) oe_cnt <= mdl_drv ? oe_cnt + 1 : 0;
    always @(posedge ram_we_n) if (sel) mem[ram_addr] = ram_dq;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
        chk({ram_cs1_n, ram_cs2, ram_oe_n, ram_we_n} === 4'b1011, "R1", "standby pins",
            {ram_cs1_n, ram_cs2, ram_oe_n, ram_we_n}, 4'b1011);
        chk(rsp_done === 1'b0, "R4", "no done after reset", rsp_done, 0);
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit busy_req);
        int n = 0, we_lo = 0, hold = 0, bad = 0, rdy_bad = 0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R2", "ready before write", req_ready, 1);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        // R9: scramble inputs; optionally keep a competing request asserted
        req_valid = busy_req; req_we = 1'b1; req_addr = ~a; req_wdata = ~d;
        while (!rsp_done && n < 40) begin
            if (req_ready) rdy_bad++;
            if (ram_addr !== a || ram_oe_n !== 1'b1 || sel !== 1'b1) bad++;
            if (!ram_we_n) begin
                we_lo++;
                if (ram_dq !== d) bad++;
            end else if (we_lo > 0) begin
                hold++;
                if (ram_dq !== d) bad++;
            end
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(n == EXP_LAT, "R2", "write latency", n, EXP_LAT);
        chk(rdy_bad == 0, "R2", "ready low while writing", rdy_bad, 0);
        chk(we_lo == EXP_WP, "R5", "WE low cycles", we_lo, EXP_WP);
        chk(hold == EXP_HOLD, "R7", "recovery cycles", hold, EXP_HOLD);
        chk(bad == 0, "R6", "address/data/strobes during write", bad, 0);
        chk(sel === 1'b0 && req_ready === 1'b1, "R1", "standby after write", sel, 0);
        @(negedge clk);
        chk(rsp_done === 1'b0, "R4", "done single cycle (write)", rsp_done, 0);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
        int n = 0, oe_lo = 0, bad = 0, turn = 0;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_wdata = 8'h5A;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        while (!rsp_done && n < 40) begin
            if (!ram_oe_n) oe_lo++;
            if (ram_we_n !== 1'b1 || ram_addr !== a || sel !== 1'b1) bad++;
            if (n == 0 && ram_oe_n !== 1'b1) bad++;
            n++;
            @(negedge clk);
        end
        chk(n == EXP_LAT, "R2", "read latency", n, EXP_LAT);
        chk(oe_lo == EXP_RD, "R3", "OE low cycles", oe_lo, EXP_RD);
        chk(bad == 0, "R3", "strobes during read", bad, 0);
        chk(rsp_rdata === exp, "R10", "read data", rsp_rdata, exp);
        while (!req_ready && turn < 40) begin
            if (sel) bad++;
            turn++;
            @(negedge clk);
        end
        chk(turn == EXP_TURN, "R8", "turnaround cycles", turn, EXP_TURN);
        chk(bad == 0, "R8", "deselected in turnaround", bad, 0);
        chk(rsp_done === 1'b0 && rsp_rdata === exp, "R4", "done single cycle, data held", rsp_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        do_write(17'h00000, 8'h3C, 1'b0);
        do_write(17'h1FFFF, 8'hC3, 1'b0);
        do_read(17'h00000, 8'h3C);
        do_read(17'h1FFFF, 8'hC3);
        // write then read of another address back to back
        do_write(17'h0A5A5, 8'h96, 1'b0);
        do_read(17'h15A5A, 8'h00);
        do_read(17'h0A5A5, 8'h96);
        // R9: request held valid during a busy write must not be taken
        do_write(17'h01234, 8'h71, 1'b1);
        do_read(17'h1EDCB, 8'h00);
        do_read(17'h01234, 8'h71);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule